// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked system and an external 32K x 8 asynchronous static RAM that has active-low chip-select, output-enable and write-enable strobes and a shared data bus. A single-word request (read or write) is handed over with a valid/ready handshake. The block turns it into a sequence of registered strobe phases. Each phase lasts a whole number of clock cycles, derived from nanosecond minimums and the clock period.

Reads hold chip select and output enable low for the access window and capture the bus into a register on the closing edge. Writes are controlled by write enable. Chip select drops first. Output enable stays high for the entire write, so the RAM never drives the bus. Write enable is pulsed while the controller drives the data, and the data is held for one more cycle after write enable rises. A write that follows a read gets a longer address phase, so the RAM has released the bus before the controller drives it. The tristate is split into a data-out vector, a driver enable and a data-in vector, ready for an FPGA I/O buffer.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While rst is high, and after it, until a request is accepted: mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, ready is 1 and rd_data is 0.
- R2: A request is accepted on a clock edge where ready and req_valid are both 1. ready is 0 from the next cycle on. It returns to 1 in the cycle after the last phase of the operation, so with req_valid held high it is 1 for exactly one cycle between operations.
- R3: A read (req_write = 0) drives mem_ce_n = 0, mem_oe_n = 0 and mem_we_n = 1 for RD_CYC cycles starting the cycle after acceptance. RD_CYC = max(1, ceil(max(T_AA_NS, T_OE_NS) * 1000 / CLK_PS)), which is 2 by default. After those cycles all strobes return to 1.
- R4: rd_data takes the value seen on mem_dq_in in the last cycle of the read strobes. It keeps that value until the next read completes.
- R5: A write (req_write = 1) keeps mem_ce_n = 0 from the cycle after acceptance, through an address phase of one cycle with mem_we_n = 1, then WP_CYC cycles with mem_we_n = 0, then one hold cycle with mem_we_n = 1. WP_CYC = max(1, ceil(max(T_WP_NS, T_AW_NS, T_DW_NS) * 1000 / CLK_PS)), which is 2 by default.
- R6: mem_oe_n is 1 throughout every write.
- R7: mem_dq_oe is 1 exactly during the write-enable-low cycles and the hold cycle after them. In those cycles mem_dq_out equals the accepted req_wdata and does not change.
- R8: Whenever no operation is in progress, the controller is in standby: mem_ce_n, mem_oe_n and mem_we_n are 1 and mem_dq_oe is 0. Changes on req_valid, req_write, req_addr and req_wdata while ready is 0 have no effect on the bus or on later results.
- R9: A write whose previous operation was a read has an address phase of 1 + TURN_CYC cycles instead of 1. TURN_CYC = max(1, ceil(T_OHZ_NS * 1000 / CLK_PS)), which is 1 by default. The data driver therefore turns on no earlier than TURN_CYC + 2 cycles after mem_oe_n rises.
- R10: mem_addr equals the accepted req_addr and stays stable for every cycle in which mem_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| ready | output | 1 | Idle and able to accept; rises when an operation completes |
| rd_data | output | DATA_W (8) | Data captured by the last read |
| mem_addr | output | ADDR_W (15) | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W (8) | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data driver toward the RAM |
| mem_dq_in | input | DATA_W (8) | Data from the RAM |

## Verification
Every strobe is registered, so each output changes exactly one edge after the decision that moves it. The read strobes occupy cycles A+1 to A+RD_CYC after acceptance edge A. rd_data and ready change together at edge A+RD_CYC. A write's driver enable rises 1 or 1+TURN_CYC cycles after acceptance, and ready returns WP_CYC+1 cycles after that. The bench's reference model turns each acceptance into a queue of expected per-cycle bus states. It compares one entry against the outputs at every falling clock edge, midway between the registering edges, so every result is checked in the cycle it is due.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WADDR,
    ST_WPULSE,
    ST_WHOLD
  } ctrl_st_e;

  // Whole clock cycles covering a nanosecond minimum, never fewer than one.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WP_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  // Address phase of a write: longer when the RAM drove the bus last.
  localparam int ADDR_PH_RD = 1 + TURN_CYC;

  ctrl_st_e st_q;
  logic     last_rd_q;

  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign capture = (st_q == ST_READ) && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (!req_write)     tmr_val = CNT_W'(RD_CYC - 1);
          else if (last_rd_q) tmr_val = CNT_W'(ADDR_PH_RD - 1);
          else                tmr_val = '0;
        end
      end
      ST_WADDR: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(WP_CYC - 1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
      ready     <= 1'b1;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            ready <= 1'b0;
            ce_n  <= 1'b0;
            if (req_write) begin
              st_q      <= ST_WADDR;
              last_rd_q <= 1'b0;
            end else begin
              st_q      <= ST_READ;
              oe_n      <= 1'b0;
              last_rd_q <= 1'b1;
            end
          end
        end
        ST_READ: begin
          if (tmr_zero) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            ready <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_WADDR: begin
          if (tmr_zero) begin
            we_n  <= 1'b0;
            dq_oe <= 1'b1;
            st_q  <= ST_WPULSE;
          end
        end
        ST_WPULSE: begin
          if (tmr_zero) begin
            we_n <= 1'b1;
            st_q <= ST_WHOLD;
          end
        end
        ST_WHOLD: begin
          dq_oe <= 1'b0;
          ce_n  <= 1'b1;
          ready <= 1'b1;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) begin
        rd_data <= mem_dq_in;
      end
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int CLK_PS   = 10000,
  parameter int T_AA_NS  = 15,
  parameter int T_OE_NS  = 8,
  parameter int T_WP_NS  = 12,
  parameter int T_AW_NS  = 12,
  parameter int T_DW_NS  = 8,
  parameter int T_OHZ_NS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = ns_to_cyc(imax(T_AA_NS, T_OE_NS), CLK_PS);
  localparam int WP_CYC   = ns_to_cyc(imax(imax(T_WP_NS, T_AW_NS), T_DW_NS), CLK_PS);
  localparam int TURN_CYC = ns_to_cyc(T_OHZ_NS, CLK_PS);
  localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), TURN_CYC + 1);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             accept;
  logic             capture;

  sram_ctrl_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  sram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .ready    (ready),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .dq_oe    (mem_dq_oe)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 10000,
  parameter int T_WP_NS = 12,
  parameter int T_AW_NS = 12,
  parameter int T_DW_NS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  localparam int WP_CYC = ns_to_cyc(imax(imax(T_WP_NS, T_AW_NS), T_DW_NS), CLK_PS);

  logic [7:0] we_low_cnt;

  always_ff @(posedge clk) begin
    if (rst)            we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 8'd1;
    else                we_low_cnt <= '0;
  end

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);

  a_r3_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  a_r5_we_needs_ce: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  a_r5_we_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt == 8'(WP_CYC)));

  a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  a_r7_drive_only_write: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

  a_r7_hold_after_we: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe);

  a_r7_data_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  a_r8_idle_standby: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  a_r10_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CLK_PS (CLK_PS),
  .T_WP_NS(T_WP_NS),
  .T_AW_NS(T_AW_NS),
  .T_DW_NS(T_DW_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .ready     (ready),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_bus_ctrl_bench.sv
module sram_bus_ctrl_bench;

  localparam int CLK_PS   = 10000;
  localparam int T_AA_NS  = 15;
  localparam int T_OE_NS  = 8;
  localparam int T_WP_NS  = 12;
  localparam int T_AW_NS  = 12;
  localparam int T_DW_NS  = 8;
  localparam int T_OHZ_NS = 8;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD   = cyc_of(mx(T_AA_NS, T_OE_NS));
  localparam int E_WP   = cyc_of(mx(mx(T_WP_NS, T_AW_NS), T_DW_NS));
  localparam int E_TURN = cyc_of(T_OHZ_NS);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  always #5 clk = ~clk;

  sram_bus_ctrl #(
    .CLK_PS(CLK_PS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS), .T_WP_NS(T_WP_NS),
    .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS), .T_OHZ_NS(T_OHZ_NS)
  ) u_sram_bus_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Behavioural RAM, folded onto 64 words; stores on the rising write strobe.
  logic [7:0] phys [0:63];
  initial begin
    for (int i = 0; i < 64; i++) phys[i] = 8'(i * 7 + 3);
    forever begin
      @(posedge mem_we_n);
      if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) phys[mem_addr[5:0]] = mem_dq_out;
    end
  end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? phys[mem_addr[5:0]] : 8'hEE;

  int nchecks = 0;
  int nerrs   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: each accepted request becomes a list of expected bus states.
  typedef struct {
    bit          ce, oe, we, dqoe;
    int          kind;   // 0 idle, 1 read, 2 write, 3 write address phase after a read
    logic [14:0] addr;
    logic [7:0]  data;
  } ent_t;

  ent_t        sched[$];
  ent_t        cur;
  ent_t        nw;
  bit          model_on = 1'b0;
  bit          ref_ready = 1'b0;
  bit          exp_rdy;
  bit          last_rd_m = 1'b0;
  bit          rd_pend = 1'b0;
  logic [7:0]  rd_pend_val;
  logic [7:0]  exp_rd = 8'h00;
  logic [7:0]  ref_m [0:63];
  int          cyc = 0;
  int          t_oe_rise = 0;
  bit          rd_gap_open = 1'b0;
  bit          prev_oe = 1'b1;
  bit          prev_dqoe = 1'b0;

  task automatic push(input bit ce, input bit oe, input bit we, input bit dq,
                      input int kind, input logic [14:0] a, input logic [7:0] d);
    nw.ce = ce; nw.oe = oe; nw.we = we; nw.dqoe = dq;
    nw.kind = kind; nw.addr = a; nw.data = d;
    sched.push_back(nw);
  endtask

  function automatic string tg(input int kind, input string idle_t, input string rd_t,
                               input string wr_t, input string ws_t);
    case (kind)
      1:       return rd_t;
      2:       return wr_t;
      3:       return ws_t;
      default: return idle_t;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!ref_ready) begin
      for (int i = 0; i < 64; i++) ref_m[i] = 8'(i * 7 + 3);
      ref_ready = 1'b1;
    end
    cyc++;
    if (model_on) begin
      if (sched.size() == 0) begin
        cur.ce = 1; cur.oe = 1; cur.we = 1; cur.dqoe = 0; cur.kind = 0;
        cur.addr = '0; cur.data = '0;
        exp_rdy = 1'b1;
        if (rd_pend) begin
          exp_rd  = rd_pend_val;
          rd_pend = 1'b0;
        end
      end else begin
        cur = sched.pop_front();
        exp_rdy = 1'b0;
      end
      chk(mem_ce_n == cur.ce, tg(cur.kind, "R8 ce_n", "R3 ce_n", "R5 ce_n", "R9 ce_n"), 32'(mem_ce_n), 32'(cur.ce));
      chk(mem_oe_n == cur.oe, tg(cur.kind, "R8 oe_n", "R3 oe_n", "R6 oe_n", "R6 oe_n"), 32'(mem_oe_n), 32'(cur.oe));
      chk(mem_we_n == cur.we, tg(cur.kind, "R8 we_n", "R3 we_n", "R5 we_n", "R9 we_n"), 32'(mem_we_n), 32'(cur.we));
      chk(mem_dq_oe == cur.dqoe, tg(cur.kind, "R8 dq_oe", "R3 dq_oe", "R7 dq_oe", "R9 dq_oe"), 32'(mem_dq_oe), 32'(cur.dqoe));
      chk(ready == exp_rdy, "R2 ready", 32'(ready), 32'(exp_rdy));
      chk(rd_data == exp_rd, "R4 rd_data", 32'(rd_data), 32'(exp_rd));
      if (!cur.ce) chk(mem_addr == cur.addr, "R10 mem_addr", 32'(mem_addr), 32'(cur.addr));
      if (cur.dqoe) chk(mem_dq_out == cur.data, "R7 mem_dq_out", 32'(mem_dq_out), 32'(cur.data));

      // R9: distance from output-enable release to the first drive of the bus
      if (!prev_oe && mem_oe_n) begin
        t_oe_rise   = cyc;
        rd_gap_open = 1'b1;
      end
      if (!prev_dqoe && mem_dq_oe && rd_gap_open) begin
        chk((cyc - t_oe_rise) >= E_TURN + 2, "R9 turnaround gap",
            32'(cyc - t_oe_rise), 32'(E_TURN + 2));
        rd_gap_open = 1'b0;
      end
      prev_oe   = mem_oe_n;
      prev_dqoe = mem_dq_oe;

      if (exp_rdy && req_valid) begin
        if (req_write) begin
          if (last_rd_m) begin
            for (int k = 0; k < 1 + E_TURN; k++) push(0, 1, 1, 0, 3, req_addr, req_wdata);
          end else begin
            push(0, 1, 1, 0, 2, req_addr, req_wdata);
          end
          for (int k = 0; k < E_WP; k++) push(0, 1, 0, 1, 2, req_addr, req_wdata);
          push(0, 1, 1, 1, 2, req_addr, req_wdata);
          ref_m[req_addr[5:0]] = req_wdata;
          last_rd_m = 1'b0;
        end else begin
          for (int k = 0; k < E_RD; k++) push(0, 0, 1, 0, 1, req_addr, 8'h00);
          rd_pend     = 1'b1;
          rd_pend_val = ref_m[req_addr[5:0]];
          last_rd_m   = 1'b1;
        end
      end
    end
  end

  // Presents one request and waits for its acceptance. With keep set,
  // req_valid stays high so the next call is queued back to back.
  task automatic op(input bit w, input logic [14:0] a, input logic [7:0] d, input bit keep);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    do @(negedge clk); while (!ready);
    @(posedge clk);
    #2;
    // scramble the fields while busy: R8 says they must be ignored
    req_addr  = ~a;
    req_wdata = ~d;
    req_write = ~w;
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchecks, nerrs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerrs++;
    $display("FAIL R2 watchdog: ready never returned actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(mem_ce_n == 1'b1, "R1 ce_n", 32'(mem_ce_n), 1);
    chk(mem_oe_n == 1'b1, "R1 oe_n", 32'(mem_oe_n), 1);
    chk(mem_we_n == 1'b1, "R1 we_n", 32'(mem_we_n), 1);
    chk(mem_dq_oe == 1'b0, "R1 dq_oe", 32'(mem_dq_oe), 0);
    chk(ready == 1'b1, "R1 ready", 32'(ready), 1);
    chk(rd_data == 8'h00, "R1 rd_data", 32'(rd_data), 0);
    @(posedge clk);
    #2;
    rst = 1'b0;
    model_on = 1'b1;
    idle(3);

    // single write then read at the lowest address (R5, R3, R4)
    op(1, 15'h0000, 8'hA5, 0);
    idle(3);
    op(0, 15'h0000, 8'h00, 0);
    idle(3);

    // back-to-back mix, top address, write after read (R2, R9)
    op(1, 15'h7FFF, 8'h3C, 1);
    op(0, 15'h7FFF, 8'h00, 1);
    op(1, 15'h0011, 8'h81, 1);
    op(0, 15'h0011, 8'h00, 1);
    op(0, 15'h0000, 8'h00, 0);
    idle(2);

    // reads of untouched words, then write-write-read-read
    op(0, 15'h0002, 8'h00, 1);
    op(0, 15'h0003, 8'h00, 1);
    op(1, 15'h0004, 8'h5A, 1);
    op(1, 15'h0005, 8'hC3, 1);
    op(0, 15'h0004, 8'h00, 1);
    op(0, 15'h0005, 8'h00, 0);
    idle(2);

    // R8: a request pulse while busy is ignored; word 7 keeps its old value
    op(1, 15'h0006, 8'h11, 0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0007; req_wdata = 8'hFF;
    @(posedge clk); #2;
    req_valid = 1'b0;
    idle(6);
    op(0, 15'h0007, 8'h00, 0);
    op(0, 15'h0006, 8'h00, 0);
    idle(2);

    // pseudo-random sequence
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[0], {r[22:17], 3'b000, r[7:2]}, r[31:24], r[1]);
    end
    idle(8);

    summary();
    $finish;
  end

endmodule